// File: doc/BRIEF.md
# Mixed-Sign Fractional Multiplier

This block is the multiplier stage of a DSP datapath. It accepts two 16-bit operands, each with its own signedness flag, widens each one separately to 17 bits, and forms their product in a 17 by 17 signed multiplier. The signedness of each operand is chosen on its own, so signed, unsigned and mixed-sign products all come from the same hardware.

A fractional-mode input treats the operands as Q15 values and doubles the product, so the result is a Q1.31 value with the radix point just after the sign bit. An integer byte mode multiplies only the low byte of each operand. In every mode the result is sign-extended to the 40-bit accumulator width. The result is registered once, and an output valid follows the input valid one clock later. The block never saturates: an out-of-range fractional result such as -1.0 times -1.0 is passed on unclipped, and the accumulator stage downstream handles it.

Top module: `dsp_mul17`

## Requirements
- R1: Each operand is widened to 17 bits on its own. With its flag high (signed), the operand's top bit is copied into bit 16. With its flag low (unsigned), bit 16 is zero. Mixed-sign pairs therefore give the exact mixed-sign product.
- R2: In integer mode (frac_mode=0, byte_mode=0), `product` equals the exact product of the two widened 16-bit operands, in two's complement and sign-extended to 40 bits.
- R3: In fractional mode (frac_mode=1), `product` is the exact product of the widened operands shifted left by one bit. Bit 0 is then always 0. No saturation is applied: signed 0x8000 times signed 0x8000 gives 0x0080000000.
- R4: In integer byte mode (frac_mode=0, byte_mode=1), only bits 7:0 of each operand are used, widened according to that operand's flag. Bits 15:8 have no effect. If both operands are unsigned, bits 39:16 of `product` are zero.
- R5: In fractional mode, `byte_mode` is ignored and the full 16-bit operands are used.
- R6: Bits 39:33 of `product` always hold one common value. They are the sign extension of a result that fits in 34 signed bits.
- R7: `out_valid` equals `in_valid` delayed by one clock. The result for operands presented with `in_valid` high appears on `product` in the following cycle.
- R8: In a cycle with `in_valid` low, `product` holds its previous value, whatever the operand and mode inputs do.
- R9: While `rst_n` is low, `out_valid` and `product` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and mode inputs are valid this cycle |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| a_signed | input | 1 | 1: op_a is signed, 0: op_a is unsigned |
| b_signed | input | 1 | 1: op_b is signed, 0: op_b is unsigned |
| frac_mode | input | 1 | 1: Q15 x Q15 to Q1.31 scaling, 0: integer |
| byte_mode | input | 1 | Integer mode only: multiply the low bytes |
| out_valid | output | 1 | `product` carries a new result |
| product | output | 40 | Registered result, sign-extended to 40 bits |

## Verification
Each result is due exactly one rising edge after its operands are accepted. The bench drives the inputs on the falling edge, and it compares `out_valid` and `product` on the next falling edge, after one register stage. After every accepted operation the bench holds `in_valid` low for one cycle with scrambled operands and modes, then checks on the next falling edge that `out_valid` has dropped and that `product` is unchanged. The sweep crosses a set of corner operand values with all sixteen flag and mode combinations, and it computes every expected value in 64-bit arithmetic.

// File: rtl/dsp_mul17_pkg.sv
package dsp_mul17_pkg;
    localparam int unsigned NUM_OPS = 2;

    typedef struct packed {
        logic        vld;
        logic [39:0] res;
    } mul_state_t;
endpackage

// File: rtl/dsp_mul17_ext.sv
module dsp_mul17_ext #(
    parameter int unsigned DATA_W = 16,
    localparam int unsigned BYTE_W = DATA_W / 2,
    localparam int unsigned EXT_W  = DATA_W + 1
) (
    input  logic [DATA_W-1:0] raw,
    input  logic              is_signed,
    input  logic              use_byte,
    output logic [EXT_W-1:0]  widened
);
    logic [BYTE_W-1:0] low_part;
    logic              word_fill;
    logic              byte_fill;

    always_comb begin
        low_part  = raw[BYTE_W-1:0];
        word_fill = is_signed & raw[DATA_W-1];
        byte_fill = is_signed & low_part[BYTE_W-1];
        if (use_byte) begin
            widened = {{(EXT_W-BYTE_W){byte_fill}}, low_part};
        end else begin
            widened = {word_fill, raw};
        end
    end
endmodule

// File: rtl/dsp_mul17_core.sv
module dsp_mul17_core #(
    parameter int unsigned EXT_W = 17,
    parameter int unsigned ACC_W = 40,
    localparam int unsigned FULL_W  = 2 * EXT_W,
    localparam int unsigned PROD_W  = FULL_W - 1,
    localparam int unsigned SCALE_W = PROD_W + 1
) (
    input  logic [EXT_W-1:0] mul_a,
    input  logic [EXT_W-1:0] mul_b,
    input  logic             scale_frac,
    output logic [ACC_W-1:0] acc_out
);
    logic signed [FULL_W-1:0] full_prod;
    logic [PROD_W-1:0]        prod_trim;
    logic [SCALE_W-1:0]       scaled;

    always_comb begin
        full_prod = $signed(mul_a) * $signed(mul_b);
        prod_trim = full_prod[PROD_W-1:0];
        if (scale_frac) begin
            scaled = {prod_trim, 1'b0};
        end else begin
            scaled = {prod_trim[PROD_W-1], prod_trim};
        end
        acc_out = {{(ACC_W-SCALE_W){scaled[SCALE_W-1]}}, scaled};
    end
endmodule

// File: rtl/dsp_mul17.sv
module dsp_mul17
    import dsp_mul17_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ACC_W  = 40,
    localparam int unsigned EXT_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              a_signed,
    input  logic              b_signed,
    input  logic              frac_mode,
    input  logic              byte_mode,
    output logic              out_valid,
    output logic [ACC_W-1:0]  product
);
    logic [DATA_W-1:0] op_raw  [NUM_OPS];
    logic              op_sgn  [NUM_OPS];
    logic [EXT_W-1:0]  op_wide [NUM_OPS];
    logic              byte_sel;
    logic [ACC_W-1:0]  core_out;
    mul_state_t        state_d, state_q;

    assign op_raw[0] = op_a;
    assign op_raw[1] = op_b;
    assign op_sgn[0] = a_signed;
    assign op_sgn[1] = b_signed;
    assign byte_sel  = byte_mode & ~frac_mode;

    for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_ext
        dsp_mul17_ext #(.DATA_W(DATA_W)) u_ext (
            .raw       (op_raw[gi]),
            .is_signed (op_sgn[gi]),
            .use_byte  (byte_sel),
            .widened   (op_wide[gi])
        );
    end

    dsp_mul17_core #(.EXT_W(EXT_W), .ACC_W(ACC_W)) u_core (
        .mul_a      (op_wide[0]),
        .mul_b      (op_wide[1]),
        .scale_frac (frac_mode),
        .acc_out    (core_out)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.res = core_out;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign product   = state_q.res;
endmodule

// File: rtl/dsp_mul17_chk.sv
module dsp_mul17_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ACC_W  = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic              a_signed,
    input logic              b_signed,
    input logic              frac_mode,
    input logic              byte_mode,
    input logic              out_valid,
    input logic [ACC_W-1:0]  product
);
    localparam int unsigned TOP_N = ACC_W - 2 * DATA_W - 1;

    assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(product));

    assert_frac_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && frac_mode) |=> (product[0] == 1'b0));

    assert_byte_unsigned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && byte_mode && !frac_mode && !a_signed && !b_signed)
        |=> (product[ACC_W-1:DATA_W] == '0));

    assert_word_unsigned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !byte_mode && !frac_mode && !a_signed && !b_signed)
        |=> (product[ACC_W-1:2*DATA_W] == '0));

    assert_sign_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(product[ACC_W-1:2*DATA_W+1]) == 0 ||
                       $countones(product[ACC_W-1:2*DATA_W+1]) == TOP_N));
endmodule

bind dsp_mul17 dsp_mul17_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .a_signed  (a_signed),
    .b_signed  (b_signed),
    .frac_mode (frac_mode),
    .byte_mode (byte_mode),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/dsp_mul17_bench.sv
module dsp_mul17_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVALS = 14;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] op_a, op_b;
    logic        a_signed, b_signed, frac_mode, byte_mode;
    logic        out_valid;
    logic [39:0] product;

    int n_checks = 0;
    int n_fails  = 0;
    int n_cycles = 0;
    logic [15:0] vals [NVALS];

    dsp_mul17 u_dsp_mul17 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .a_signed(a_signed), .b_signed(b_signed),
        .frac_mode(frac_mode), .byte_mode(byte_mode),
        .out_valid(out_valid), .product(product)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        n_cycles <= n_cycles + 1;
        if (n_cycles > WATCHDOG) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles, expected at most %0d", n_cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic check40(string req, logic [39:0] act, logic [39:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check1(string req, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic longint widen(logic [15:0] v, bit sgn, bit byt);
        if (byt) return sgn ? longint'($signed(v[7:0])) : longint'({56'b0, v[7:0]});
        return sgn ? longint'($signed(v)) : longint'({48'b0, v});
    endfunction

    function automatic logic [39:0] model(logic [15:0] a, logic [15:0] b,
                                          bit sa, bit sb, bit fr, bit by);
        longint p;
        bit use_byte;
        use_byte = by && !fr;
        p = widen(a, sa, use_byte) * widen(b, sb, use_byte);
        if (fr) p = p * 2;
        return p[39:0];
    endfunction

    initial begin
        vals[0] = 16'h0000;  vals[1] = 16'h0001;  vals[2] = 16'h0002;
        vals[3] = 16'h007F;  vals[4] = 16'h0080;  vals[5] = 16'h00FF;
        vals[6] = 16'h0100;  vals[7] = 16'h7FFF;  vals[8] = 16'h8000;
        vals[9] = 16'h8001;  vals[10] = 16'hFFFF; vals[11] = 16'h1234;
        vals[12] = 16'hA5C3; vals[13] = 16'h7F80;

        rst_n = 1'b0; in_valid = 1'b1;
        op_a = 16'hFFFF; op_b = 16'hFFFF;
        a_signed = 1'b0; b_signed = 1'b0; frac_mode = 1'b0; byte_mode = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset clears both outputs even with in_valid high
        check1("R9 out_valid in reset", out_valid, 1'b0);
        check40("R9 product in reset", product, 40'h0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check1("R9 out_valid after reset", out_valid, 1'b0);
        check40("R9 product after reset", product, 40'h0);

        // R3: directed corner -1.0 x -1.0 is not saturated
        in_valid = 1'b1; op_a = 16'h8000; op_b = 16'h8000;
        a_signed = 1'b1; b_signed = 1'b1; frac_mode = 1'b1; byte_mode = 1'b0;
        @(negedge clk);
        check40("R3 frac 8000x8000", product, 40'h0080000000);
        // R5: byte_mode ignored in fractional mode
        byte_mode = 1'b1;
        @(negedge clk);
        check40("R5 frac with byte_mode", product, 40'h0080000000);
        // R4: upper byte ignored in integer byte mode
        frac_mode = 1'b0; op_a = 16'hAB03; op_b = 16'h5C05;
        a_signed = 1'b0; b_signed = 1'b0;
        @(negedge clk);
        check40("R4 byte upper ignored", product, 40'h000000000F);
        // R1: mixed-sign word, signed -1 x unsigned 0xFFFF
        byte_mode = 1'b0; op_a = 16'hFFFF; op_b = 16'hFFFF;
        a_signed = 1'b1; b_signed = 1'b0;
        @(negedge clk);
        check40("R1 mixed -1 x 65535", product, 40'hFFFFFF0001);

        for (int ia = 0; ia < NVALS; ia++) begin
            for (int ib = 0; ib < NVALS; ib++) begin
                for (int m = 0; m < 16; m++) begin
                    logic [39:0] exp;
                    string tag;
                    in_valid = 1'b1;
                    op_a = vals[ia]; op_b = vals[ib];
                    a_signed = m[0]; b_signed = m[1];
                    frac_mode = m[2]; byte_mode = m[3];
                    exp = model(vals[ia], vals[ib], m[0], m[1], m[2], m[3]);
                    if (m[2]) tag = m[3] ? "R5 frac sweep" : "R3 frac sweep";
                    else if (m[3]) tag = "R4 byte sweep";
                    else tag = (m[0] != m[1]) ? "R1 mixed sweep" : "R2 word sweep";
                    @(negedge clk);
                    check1("R7 valid follows", out_valid, 1'b1);
                    check40(tag, product, exp);
                    check1("R6 guard bits", ((&product[39:33]) || !(|product[39:33])), 1'b1);
                    // idle cycle with scrambled inputs
                    in_valid = 1'b0;
                    op_a = ~op_a; op_b = op_b ^ 16'h5A5A;
                    frac_mode = ~frac_mode; byte_mode = ~byte_mode; a_signed = ~a_signed;
                    @(negedge clk);
                    check1("R7 valid drops", out_valid, 1'b0);
                    check40("R8 hold when idle", product, exp);
                end
            end
        end
        finish_run();
    end
endmodule